// File: doc/BRIEF.md
# Eight-bit ALU with status flags

This block is the arithmetic unit of a small microcoded processor. It holds two 8-bit operand registers, primary and secondary, which are loaded from the shared data bus. Each clock cycle the microcode presents a 4-bit operation code. When the top bit of that code is set, the unit computes an arithmetic or logic result and drives it onto the bus in the same cycle. When the top bit is clear, the operation is a special one. It drives nothing and only changes an operand register or a status flag at the next clock edge.

The unit owns five bits of the processor status byte: carry, zero, less, equal and greater. The sixth bit, halt, belongs to other logic and is passed through from an input. Carry is the only flag that arithmetic writes. Zero changes only on the check-zero operation. The three compare bits change only on compare.

Top module: `byte_alu_flags`

## Requirements
- R1: After reset both operand registers are zero, all five owned flags are zero and the bus output is released (`bus_drive` low, `bus_out` zero).
- R2: Code 0011 loads the primary register and code 0100 loads the secondary register from `bus_in` at the clock edge; no other code changes either register.
- R3: Code 1000 drives primary+secondary modulo 256 and code 1001 drives primary−secondary modulo 256; at the edge carry takes the carry-out of the add, or the borrow of the subtract (set when primary < secondary).
- R4: Code 1010 drives primary+secondary+carry and code 1011 drives primary−secondary−carry, both modulo 256, using the carry held before the edge; carry then takes the new carry-out or borrow.
- R5: Code 1100 drives the bitwise NAND and code 1101 the bitwise OR of the two operands; carry is left unchanged.
- R6: `bus_drive` is high in exactly the cycles where the code is one of 1000 to 1101, and `bus_out` is zero whenever `bus_drive` is low.
- R7: Code 0001 compares the registers as unsigned numbers: exactly one of less (primary < secondary), equal or greater is set at the edge and the other two are cleared.
- R8: Code 0010 sets zero when the primary register is 0 and clears it otherwise.
- R9: Code 0000 and the unused codes 0101, 0110, 0111, 1110 and 1111 change no register or flag and leave the bus released.
- R10: `status_out` is {halt, greater, equal, less, carry, zero} from bit 5 down to bit 0, with halt equal to `halt_in` in the same cycle.
- R11: Carry changes only on codes 1000 to 1011, zero only on 0010, and less/equal/greater only on 0001.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_code | input | 4 | Operation code for the current cycle |
| bus_in | input | 8 | Value currently on the shared data bus |
| bus_out | output | 8 | Result offered to the bus, zero when not driving |
| bus_drive | output | 1 | High while the unit drives the bus |
| halt_in | input | 1 | Halt bit from outside, passed into the status byte |
| status_out | output | 6 | Status byte {H,G,E,L,C,Z} |

## Verification
On the extended add and subtract codes, two things happen in one cycle. The unit drives a result that depends on the old carry, and at the closing edge it overwrites that same carry. The bench provokes this by chaining an add that overflows into an add-with-carry, and a subtract that borrows into a subtract-with-borrow. It then judges the bus value that was sampled before the edge against a model that uses the old carry, and the status byte that was sampled after the edge against the new carry. Bus values present during arithmetic are also checked to leave the operand registers unchanged.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int DW = 8;
    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_NOP  = 4'b0000,
        OP_CMP  = 4'b0001,
        OP_CZ   = 4'b0010,
        OP_LDP  = 4'b0011,
        OP_LDS  = 4'b0100,
        OP_ADD  = 4'b1000,
        OP_SUB  = 4'b1001,
        OP_ADC  = 4'b1010,
        OP_SBB  = 4'b1011,
        OP_NAND = 4'b1100,
        OP_OR   = 4'b1101
    } op_e;

    typedef struct packed {
        logic drive;
        logic upd_c;
        logic ld_p;
        logic ld_s;
        logic do_cmp;
        logic do_cz;
    } ctl_t;

    typedef struct packed {
        logic [DW-1:0] prim;
        logic [DW-1:0] sec;
        logic          c;
        logic          z;
        logic          l;
        logic          e;
        logic          g;
    } state_t;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  logic [OPW-1:0] op_code,
    output ctl_t           ctl
);
    always_comb begin
        ctl = '0;
        case (op_code)
            OP_CMP:  ctl.do_cmp = 1'b1;
            OP_CZ:   ctl.do_cz  = 1'b1;
            OP_LDP:  ctl.ld_p   = 1'b1;
            OP_LDS:  ctl.ld_s   = 1'b1;
            OP_ADD, OP_SUB, OP_ADC, OP_SBB: begin
                ctl.drive = 1'b1;
                ctl.upd_c = 1'b1;
            end
            OP_NAND, OP_OR: ctl.drive = 1'b1;
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/alu_compute.sv
module alu_compute
    import alu_pkg::*;
(
    input  logic [OPW-1:0] op_code,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    input  logic           cin,
    output logic [DW-1:0]  res,
    output logic           cout
);
    logic [DW:0] wide;
    logic [DW:0] cin_w;

    assign cin_w = {{DW{1'b0}}, cin};

    always_comb begin
        wide = '0;
        case (op_code)
            OP_ADD:  wide = {1'b0, a} + {1'b0, b};
            OP_SUB:  wide = {1'b0, a} - {1'b0, b};
            OP_ADC:  wide = {1'b0, a} + {1'b0, b} + cin_w;
            OP_SBB:  wide = {1'b0, a} - {1'b0, b} - cin_w;
            OP_NAND: wide = {1'b0, ~(a & b)};
            OP_OR:   wide = {1'b0, a | b};
            default: wide = '0;
        endcase
        res  = wide[DW-1:0];
        cout = wide[DW];
    end
endmodule

// File: rtl/byte_alu_flags.sv
module byte_alu_flags
    import alu_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [3:0]     op_code,
    input  logic [7:0]     bus_in,
    output logic [7:0]     bus_out,
    output logic           bus_drive,
    input  logic           halt_in,
    output logic [5:0]     status_out
);
    ctl_t          ctl;
    logic [DW-1:0] res;
    logic          cout;
    state_t        st_d, st_q;

    alu_decode u_dec (
        .op_code (op_code),
        .ctl     (ctl)
    );

    alu_compute u_cmp (
        .op_code (op_code),
        .a       (st_q.prim),
        .b       (st_q.sec),
        .cin     (st_q.c),
        .res     (res),
        .cout    (cout)
    );

    always_comb begin
        st_d = st_q;
        if (ctl.ld_p) st_d.prim = bus_in;
        if (ctl.ld_s) st_d.sec  = bus_in;
        if (ctl.upd_c) st_d.c = cout;
        if (ctl.do_cz) st_d.z = (st_q.prim == '0);
        if (ctl.do_cmp) begin
            st_d.l = (st_q.prim <  st_q.sec);
            st_d.e = (st_q.prim == st_q.sec);
            st_d.g = (st_q.prim >  st_q.sec);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_drive  = ctl.drive;
    assign bus_out    = ctl.drive ? res : '0;
    assign status_out = {halt_in, st_q.g, st_q.e, st_q.l, st_q.c, st_q.z};

    // Bus released whenever the top code bit is clear
    assert_bus_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !op_code[3] |-> (!bus_drive && bus_out == 8'h00));

    // Compare leaves exactly one relation bit set
    assert_cmp_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'b0001) |=> ($countones(status_out[4:2]) == 1));

    // Compare bits move only on compare
    assert_leg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code != 4'b0001) |=> $stable(status_out[4:2]));

    // Carry moves only on the four add/subtract codes
    assert_carry_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code[3:2] != 2'b10) |=> $stable(status_out[1]));

    // Check-zero result follows the primary register value before the edge
    assert_cz_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'b0010) |=> (status_out[0] == ($past(st_q.prim) == 8'h00)));

    // Primary register written only by its load code
    assert_prim_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code != 4'b0011) |=> $stable(st_q.prim));

    // Halt pass-through
    always_comb begin
        assert_halt_pass_R10: assert (status_out[5] == halt_in);
    end
endmodule

// File: tb/test_byte_alu_flags.sv
module test_byte_alu_flags;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_code = 4'h0;
    logic [7:0] bus_in = 8'h00;
    logic       halt_in = 1'b0;
    logic [7:0] bus_out;
    logic       bus_drive;
    logic [5:0] status_out;

    byte_alu_flags i_byte_alu_flags (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .bus_in(bus_in),
        .bus_out(bus_out), .bus_drive(bus_drive), .halt_in(halt_in),
        .status_out(status_out)
    );

    always #2 clk = ~clk;

    typedef struct packed {
        logic       drive;
        logic [7:0] bus;
        logic [5:0] stat;
        logic [7:0] req;
    } item_t;

    item_t q[$];
    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model state
    logic [7:0] mp = 0, ms = 0;
    logic mc = 0, mz = 0, ml = 0, me = 0, mg = 0;

    task automatic chk(input int req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_op(input logic [3:0] op, input logic [7:0] bv, input logic h, input int req);
        item_t it;
        logic [8:0] w;
        logic drv;
        w = 9'h0;
        drv = 1'b0;
        @(negedge clk);
        op_code = op; bus_in = bv; halt_in = h;
        case (op)
            4'b1000: begin w = {1'b0,mp} + {1'b0,ms}; drv = 1; end
            4'b1001: begin w = {1'b0,mp} - {1'b0,ms}; drv = 1; end
            4'b1010: begin w = {1'b0,mp} + {1'b0,ms} + {8'h0,mc}; drv = 1; end
            4'b1011: begin w = {1'b0,mp} - {1'b0,ms} - {8'h0,mc}; drv = 1; end
            4'b1100: begin w = {1'b0, ~(mp & ms)}; drv = 1; end
            4'b1101: begin w = {1'b0, mp | ms}; drv = 1; end
            default: ;
        endcase
        it.drive = drv;
        it.bus = drv ? w[7:0] : 8'h00;
        it.req = 8'(req);
        if (op[3:2] == 2'b10) mc = w[8];
        if (op == 4'b0001) begin ml = mp < ms; me = mp == ms; mg = mp > ms; end
        if (op == 4'b0010) mz = (mp == 0);
        if (op == 4'b0011) mp = bv;
        if (op == 4'b0100) ms = bv;
        it.stat = {h, mg, me, ml, mc, mz};
        q.push_back(it);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            item_t it;
            logic d;
            logic [7:0] b;
            @(negedge clk);
            #1;
            if (q.size() != 0) begin
                it = q.pop_front();
                d = bus_drive; b = bus_out;
                @(posedge clk);
                #1;
                chk(int'(it.req), "bus_drive", int'(d), int'(it.drive));
                chk(int'(it.req), "bus_out", int'(b), int'(it.bus));
                chk(int'(it.req), "status", int'(status_out), int'(it.stat));
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #9 rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(1, "reset status", int'(status_out), 0);
        chk(1, "reset drive", int'(bus_drive), 0);
        chk(1, "reset bus", int'(bus_out), 0);
        do_op(4'b1101, 8'h00, 0, 1);      // R1: OR of zero operands is zero
        // R2 loads
        do_op(4'b0011, 8'd200, 0, 2);
        do_op(4'b0100, 8'd100, 0, 2);
        do_op(4'b1101, 8'hFF, 0, 2);      // R2: OR exposes both registers, bus_in ignored
        // R3 / R4 carry chain: add overflows, ADC uses old carry
        do_op(4'b1000, 8'h55, 0, 3);
        do_op(4'b1010, 8'h00, 0, 4);
        do_op(4'b1001, 8'h00, 0, 3);      // R3 200-100, no borrow
        do_op(4'b0011, 8'd50, 0, 2);
        do_op(4'b1001, 8'h00, 0, 3);      // R3 borrow
        do_op(4'b1011, 8'h00, 0, 4);      // R4 uses borrow
        do_op(4'b1011, 8'h00, 0, 4);
        // R5 logic ops keep carry
        do_op(4'b1100, 8'h00, 0, 5);
        do_op(4'b1101, 8'h00, 0, 5);
        // R7 compare all three outcomes
        do_op(4'b0001, 8'h00, 0, 7);
        do_op(4'b0100, 8'd50, 0, 2);
        do_op(4'b0001, 8'h00, 0, 7);
        do_op(4'b0100, 8'd0, 0, 2);
        do_op(4'b0001, 8'h00, 0, 7);
        // R8 check-zero both ways
        do_op(4'b0010, 8'h00, 0, 8);
        do_op(4'b0011, 8'd0, 0, 2);
        do_op(4'b0010, 8'h00, 0, 8);
        // R9 NOP and unused codes, R11 flags hold
        do_op(4'b0000, 8'hAA, 0, 9);
        do_op(4'b0101, 8'hAA, 0, 9);
        do_op(4'b0110, 8'hAA, 0, 9);
        do_op(4'b0111, 8'hAA, 0, 9);
        do_op(4'b1110, 8'hAA, 0, 9);
        do_op(4'b1111, 8'hAA, 0, 9);
        do_op(4'b1101, 8'h00, 0, 11);     // R11 nothing above moved the registers
        // R10 halt passthrough, R6 drive pattern
        do_op(4'b0000, 8'h00, 1, 10);
        do_op(4'b1000, 8'h00, 1, 6);
        do_op(4'b0011, 8'hFF, 1, 6);
        do_op(4'b0100, 8'h01, 0, 6);
        do_op(4'b1000, 8'h00, 0, 3);      // R3 255+1 wraps with carry
        do_op(4'b1010, 8'h00, 0, 4);
        repeat (4) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule